// File: doc/BRIEF.md
# Pipeline Exception and Interrupt Annul Unit

This control block sits beside a five-stage pipeline (fetch, register read, ALU, memory, write-back). It takes four event requests: an illegal-opcode flag from register read, arithmetic faults from the ALU stage, memory faults from the memory stage, and an asynchronous interrupt line. It also takes the pipeline's load-use stall request. Each cycle it decides, per stage, whether the instruction held there is kept, turned into a no-op, or rewritten into a forced link instruction. It also steers the next fetch to the proper handler address.

The forced link instruction is a branch that is never taken and that links PC+4 into exception register 30. It sets up a return address without any extra datapath port. The unit follows each forced link down the pipe. It raises the register-30 write when the instruction reaches write-back, and it offers the in-flight value for forwarding so that the handler can read register 30 at once. An interrupt rewrites the instruction in fetch, which never executes, so its handler returns to the saved value minus 4.

Top module: `exc_annul_unit`

## Requirements
- R1: An illegal opcode in register read, with no ALU or memory fault, sets ann_rf to 2 (link), ann_if to 1 (no-op), ann_alu and ann_mem to 0 (keep), and pc_sel to 1, with handler_pc = ILLOP_PC.
- R2: An ALU fault with no memory fault sets ann_alu to 2, ann_rf and ann_if to 1, ann_mem to 0, and pc_sel to 2, with handler_pc = FAULT_PC.
- R3: A memory fault sets ann_mem to 2, ann_alu, ann_rf and ann_if to 1, and pc_sel to 2, with handler_pc = FAULT_PC.
- R4: An interrupt with no other event sets ann_if to 2, leaves ann_rf, ann_alu and ann_mem at 0, and sets pc_sel to 3, with handler_pc = IRQ_PC.
- R5: When events coincide, the one in the furthest-along stage wins (memory, then ALU, then register read, then interrupt), and at most one stage carries code 2.
- R6: stall_out follows stall_in only when no event is taken (pc_sel = 0). A taken event forces it to 0.
- R7: A forced link writes its own PC+4 to register 30 (xp_we = 1, xp_addr = 30) in the cycle it occupies write-back. Without stalls this is 1, 2, 3 or 4 clock edges after a memory fault, ALU fault, illegal opcode or interrupt.
- R8: For an interrupt, xp_data minus 4 equals the PC of the fetch-stage instruction that was rewritten.
- R9: While forced links sit in ALU, memory or write-back, xp_fwd_valid = 1 and xp_fwd_data is the value of the youngest of them (ALU before memory before write-back).
- R10: A forced link that is flushed by a later event in an older stage never writes register 30.
- R11: A forced link in register read is held there while stall_out = 1, which delays its write by the stall length.
- R12: After reset all annul codes and pc_sel are 0, handler_pc is 0, and xp_we and xp_fwd_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| illop_rf | input | 1 | Illegal opcode seen in register read |
| fault_alu | input | 1 | Arithmetic fault in the ALU stage |
| fault_mem | input | 1 | Memory fault in the memory stage |
| irq | input | 1 | Interrupt request |
| stall_in | input | 1 | Load-use stall request |
| pc_if | input | 32 | PC of the fetch-stage instruction |
| pc_rf | input | 32 | PC of the register-read instruction |
| pc_alu | input | 32 | PC of the ALU-stage instruction |
| pc_mem | input | 32 | PC of the memory-stage instruction |
| ann_if | output | 2 | Fetch annul code: 0 keep, 1 no-op, 2 link |
| ann_rf | output | 2 | Register-read annul code |
| ann_alu | output | 2 | ALU annul code |
| ann_mem | output | 2 | Memory annul code |
| pc_sel | output | 2 | 0 sequential, 1 illegal-op, 2 fault, 3 interrupt |
| handler_pc | output | 32 | Handler address for pc_sel, 0 when sequential |
| stall_out | output | 1 | Stall after exception override |
| xp_we | output | 1 | Register-30 write enable at write-back |
| xp_addr | output | 5 | Destination register, always 30 |
| xp_data | output | 32 | Saved PC+4 |
| xp_fwd_valid | output | 1 | A forced link is in flight past register read |
| xp_fwd_data | output | 32 | Youngest in-flight link value |

## Verification
A table drives every single event alone, with and without stall, and then overlapping events. Comparing the four annul codes and pc_sel tells which stage was rewritten from which stages were flushed, and shows which source won. Directed sequences follow each event kind to write-back, so that the arrival cycle and the stored PC+4 tell the four insertion points apart. Further sequences put two links in flight to test forwarding order, flush an interrupt link with a later ALU fault, and stall a link in register read to show that it is held and not dropped.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int PC_W  = 32;
  localparam int REG_W = 5;
  localparam int N_SRC = 4;   // 0 mem, 1 alu, 2 illop, 3 irq (oldest first)

  typedef enum logic [1:0] {ANN_KEEP = 2'd0, ANN_NOP = 2'd1, ANN_LINK = 2'd2} ann_e;
  typedef enum logic [1:0] {PCS_SEQ = 2'd0, PCS_ILLOP = 2'd1, PCS_FAULT = 2'd2,
                            PCS_IRQ = 2'd3} pcsel_e;

  function automatic logic [PC_W-1:0] link_of(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction
endpackage

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
(
  input  logic [N_SRC-1:0] req,
  output logic [N_SRC-1:0] grant
);
  logic [N_SRC:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
endmodule

// File: rtl/exc_annul.sv
module exc_annul
  import exc_pkg::*;
(
  input  logic [N_SRC-1:0] grant,
  input  logic             stall_in,
  output ann_e             ann [N_SRC],  // index 0 fetch .. 3 memory
  output pcsel_e           pc_sel,
  output logic             stall_out
);
  // source i lives in stage N_SRC-1-i
  for (genvar s = 0; s < N_SRC; s++) begin : g_stage
    logic older_hit;
    always_comb begin
      older_hit = 1'b0;
      for (int t = s + 1; t < N_SRC; t++) older_hit |= grant[N_SRC-1-t];
    end
    assign ann[s] = grant[N_SRC-1-s] ? ANN_LINK : (older_hit ? ANN_NOP : ANN_KEEP);
  end

  always_comb begin
    if (grant[0] | grant[1]) pc_sel = PCS_FAULT;
    else if (grant[2])       pc_sel = PCS_ILLOP;
    else if (grant[3])       pc_sel = PCS_IRQ;
    else                     pc_sel = PCS_SEQ;
  end

  assign stall_out = stall_in & ~(|grant);
endmodule

// File: rtl/exc_link_track.sv
module exc_link_track
  import exc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] grant,
  input  logic             stall_eff,
  input  logic [PC_W-1:0]  pc_if,
  input  logic [PC_W-1:0]  pc_rf,
  input  logic [PC_W-1:0]  pc_alu,
  input  logic [PC_W-1:0]  pc_mem,
  output logic             xp_we,
  output logic [PC_W-1:0]  xp_data,
  output logic             fwd_valid,
  output logic [PC_W-1:0]  fwd_data
);
  logic g_mem, g_alu, g_ill, g_irq;
  assign {g_irq, g_ill, g_alu, g_mem} = grant;

  logic            tok_rf, tok_alu, tok_mem, tok_wb;
  logic [PC_W-1:0] d_rf, d_alu, d_mem, d_wb;

  always_ff @(posedge clk) begin
    if (rst) begin
      tok_rf <= 1'b0; tok_alu <= 1'b0; tok_mem <= 1'b0; tok_wb <= 1'b0;
      d_rf <= '0; d_alu <= '0; d_mem <= '0; d_wb <= '0;
    end else begin
      tok_rf  <= g_irq | (stall_eff & tok_rf);
      d_rf    <= g_irq ? link_of(pc_if) : d_rf;
      tok_alu <= ~stall_eff & (g_ill | (tok_rf & ~g_alu & ~g_mem));
      d_alu   <= g_ill ? link_of(pc_rf) : d_rf;
      tok_mem <= g_alu | (tok_alu & ~g_mem);
      d_mem   <= g_alu ? link_of(pc_alu) : d_alu;
      tok_wb  <= g_mem | tok_mem;
      d_wb    <= g_mem ? link_of(pc_mem) : d_mem;
    end
  end

  assign xp_we     = tok_wb;
  assign xp_data   = d_wb;
  assign fwd_valid = tok_alu | tok_mem | tok_wb;
  assign fwd_data  = tok_alu ? d_alu : (tok_mem ? d_mem : d_wb);
endmodule

// File: rtl/exc_annul_unit.sv
module exc_annul_unit
  import exc_pkg::*;
#(
  parameter logic [31:0] ILLOP_PC = 32'h0000_0004,
  parameter logic [31:0] FAULT_PC = 32'h0000_0008,
  parameter logic [31:0] IRQ_PC   = 32'h0000_000C,
  parameter logic [4:0]  XP_REG   = 5'd30
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        illop_rf,
  input  logic        fault_alu,
  input  logic        fault_mem,
  input  logic        irq,
  input  logic        stall_in,
  input  logic [31:0] pc_if,
  input  logic [31:0] pc_rf,
  input  logic [31:0] pc_alu,
  input  logic [31:0] pc_mem,
  output logic [1:0]  ann_if,
  output logic [1:0]  ann_rf,
  output logic [1:0]  ann_alu,
  output logic [1:0]  ann_mem,
  output logic [1:0]  pc_sel,
  output logic [31:0] handler_pc,
  output logic        stall_out,
  output logic        xp_we,
  output logic [4:0]  xp_addr,
  output logic [31:0] xp_data,
  output logic        xp_fwd_valid,
  output logic [31:0] xp_fwd_data
);
  logic [N_SRC-1:0] req, grant;
  ann_e             ann [N_SRC];
  pcsel_e           sel;
  logic             stall_eff;

  assign req = {irq, illop_rf, fault_alu, fault_mem};

  exc_prio u_prio (.req(req), .grant(grant));

  exc_annul u_annul (
    .grant(grant), .stall_in(stall_in),
    .ann(ann), .pc_sel(sel), .stall_out(stall_eff)
  );

  exc_link_track u_track (
    .clk(clk), .rst(rst), .grant(grant), .stall_eff(stall_eff),
    .pc_if(pc_if), .pc_rf(pc_rf), .pc_alu(pc_alu), .pc_mem(pc_mem),
    .xp_we(xp_we), .xp_data(xp_data),
    .fwd_valid(xp_fwd_valid), .fwd_data(xp_fwd_data)
  );

  always_comb begin
    case (sel)
      PCS_ILLOP: handler_pc = ILLOP_PC;
      PCS_FAULT: handler_pc = FAULT_PC;
      PCS_IRQ:   handler_pc = IRQ_PC;
      default:   handler_pc = '0;
    endcase
  end

  assign ann_if    = ann[0];
  assign ann_rf    = ann[1];
  assign ann_alu   = ann[2];
  assign ann_mem   = ann[3];
  assign pc_sel    = sel;
  assign stall_out = stall_eff;
  assign xp_addr   = XP_REG;
endmodule

// File: rtl/exc_annul_unit_chk.sv
module exc_annul_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        illop_rf,
  input logic        fault_alu,
  input logic        fault_mem,
  input logic        irq,
  input logic [31:0] pc_mem,
  input logic [1:0]  ann_if,
  input logic [1:0]  ann_rf,
  input logic [1:0]  ann_alu,
  input logic [1:0]  ann_mem,
  input logic [1:0]  pc_sel,
  input logic        stall_out,
  input logic        xp_we,
  input logic [31:0] xp_data
);
  AST_ILLOP_REWRITE: assert property (@(posedge clk) disable iff (rst)
    (illop_rf && !fault_alu && !fault_mem) |-> (ann_rf == 2'd2 && ann_if == 2'd1 && pc_sel == 2'd1)); // R1
  AST_ALU_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (fault_alu && !fault_mem) |-> (ann_alu == 2'd2 && ann_rf == 2'd1 && ann_if == 2'd1 && ann_mem == 2'd0)); // R2
  AST_MEM_FLUSH: assert property (@(posedge clk) disable iff (rst)
    fault_mem |-> (ann_mem == 2'd2 && ann_alu == 2'd1 && ann_rf == 2'd1 && ann_if == 2'd1)); // R3
  AST_IRQ_FETCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    (irq && !illop_rf && !fault_alu && !fault_mem) |-> (ann_if == 2'd2 && ann_rf == 2'd0 && ann_alu == 2'd0 && ann_mem == 2'd0)); // R4
  AST_SINGLE_LINK: assert property (@(posedge clk) disable iff (rst)
    $countones({ann_if == 2'd2, ann_rf == 2'd2, ann_alu == 2'd2, ann_mem == 2'd2}) <= 1); // R5
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (pc_sel != 2'd0) |-> !stall_out); // R6
  AST_MEM_LINK_WB: assert property (@(posedge clk) disable iff (rst)
    fault_mem |=> (xp_we && xp_data == $past(pc_mem) + 32'd4)); // R7
endmodule

bind exc_annul_unit exc_annul_unit_chk u_chk (
  .clk(clk), .rst(rst), .illop_rf(illop_rf), .fault_alu(fault_alu),
  .fault_mem(fault_mem), .irq(irq), .pc_mem(pc_mem),
  .ann_if(ann_if), .ann_rf(ann_rf), .ann_alu(ann_alu), .ann_mem(ann_mem),
  .pc_sel(pc_sel), .stall_out(stall_out), .xp_we(xp_we), .xp_data(xp_data)
);

// File: tb/exc_annul_unit_test.sv
`timescale 1ns/100ps
module exc_annul_unit_test;
  localparam logic [31:0] A_ILL = 32'h0000_0004;
  localparam logic [31:0] A_FLT = 32'h0000_0008;
  localparam logic [31:0] A_IRQ = 32'h0000_000C;

  logic clk = 1'b0, rst = 1'b1;
  logic illop_rf = 0, fault_alu = 0, fault_mem = 0, irq = 0, stall_in = 0;
  logic [31:0] pc_if = 0, pc_rf = 0, pc_alu = 0, pc_mem = 0;
  logic [1:0]  ann_if, ann_rf, ann_alu, ann_mem, pc_sel;
  logic [31:0] handler_pc, xp_data, xp_fwd_data;
  logic [4:0]  xp_addr;
  logic        stall_out, xp_we, xp_fwd_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_annul_unit uut (.*);

  typedef struct packed {
    logic ill, alu, mem, irq, stall;
    logic [1:0] eif, erf, ealu, emem, esel;
    logic est;
  } vec_t;

  // codes: 0 keep, 1 nop, 2 link ; sel 0 seq, 1 illop, 2 fault, 3 irq
  localparam vec_t VEC [12] = '{
    '{0,0,0,0,0, 2'd0,2'd0,2'd0,2'd0, 2'd0, 1'b0},  // idle
    '{0,0,0,0,1, 2'd0,2'd0,2'd0,2'd0, 2'd0, 1'b1},  // R6 stall passes
    '{1,0,0,0,0, 2'd1,2'd2,2'd0,2'd0, 2'd1, 1'b0},  // R1
    '{1,0,0,0,1, 2'd1,2'd2,2'd0,2'd0, 2'd1, 1'b0},  // R1 R6
    '{0,1,0,0,0, 2'd1,2'd1,2'd2,2'd0, 2'd2, 1'b0},  // R2
    '{0,0,1,0,0, 2'd1,2'd1,2'd1,2'd2, 2'd2, 1'b0},  // R3
    '{0,0,0,1,0, 2'd2,2'd0,2'd0,2'd0, 2'd3, 1'b0},  // R4
    '{0,0,0,1,1, 2'd2,2'd0,2'd0,2'd0, 2'd3, 1'b0},  // R4 R6
    '{1,0,0,1,0, 2'd1,2'd2,2'd0,2'd0, 2'd1, 1'b0},  // R5 illop over irq
    '{1,1,0,0,0, 2'd1,2'd1,2'd2,2'd0, 2'd2, 1'b0},  // R5 alu over illop
    '{1,1,1,1,1, 2'd1,2'd1,2'd1,2'd2, 2'd2, 1'b0},  // R5 mem over all
    '{0,1,0,1,0, 2'd1,2'd1,2'd2,2'd0, 2'd2, 1'b0}   // R5 alu over irq
  };

  function automatic logic [31:0] exp_handler(input logic [1:0] s);
    case (s)
      2'd1: return A_ILL;
      2'd2: return A_FLT;
      2'd3: return A_IRQ;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    illop_rf = 0; fault_alu = 0; fault_mem = 0; irq = 0; stall_in = 0;
  endtask

  task automatic do_reset();
    quiet();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R12 reset state
    chk({ann_if, ann_rf, ann_alu, ann_mem, pc_sel} == 10'd0 && handler_pc == 0 && !xp_we && !xp_fwd_valid,
        "R12 reset", {ann_if, ann_rf, ann_alu, ann_mem, pc_sel, xp_we, xp_fwd_valid}, 0);

    for (int i = 0; i < 12; i++) begin
      {illop_rf, fault_alu, fault_mem, irq, stall_in} =
        {VEC[i].ill, VEC[i].alu, VEC[i].mem, VEC[i].irq, VEC[i].stall};
      pc_if = 32'h1000 + i; pc_rf = 32'h2000; pc_alu = 32'h3000; pc_mem = 32'h4000;
      #1;
      chk({ann_if, ann_rf, ann_alu, ann_mem, pc_sel, stall_out} ==
          {VEC[i].eif, VEC[i].erf, VEC[i].ealu, VEC[i].emem, VEC[i].esel, VEC[i].est}
          && handler_pc == exp_handler(VEC[i].esel),
          $sformatf("R1-table vector %0d (R2 R3 R4 R5 R6)", i),
          {ann_if, ann_rf, ann_alu, ann_mem, pc_sel, stall_out, handler_pc},
          {VEC[i].eif, VEC[i].erf, VEC[i].ealu, VEC[i].emem, VEC[i].esel, VEC[i].est,
           exp_handler(VEC[i].esel)});
      tick();
    end

    // R7 R8 interrupt link reaches write-back after 4 edges
    do_reset();
    pc_if = 32'h100; irq = 1; tick(); quiet();
    tick();
    chk(xp_fwd_valid && xp_fwd_data == 32'h104, "R9 irq link in ALU", xp_fwd_data, 32'h104);
    tick();
    chk(!xp_we, "R7 irq not yet at wb", xp_we, 0);
    tick();
    chk(xp_we && xp_addr == 5'd30 && xp_data == 32'h104, "R7 irq write", {xp_we, xp_addr, xp_data}, {1'b1, 5'd30, 32'h104});
    chk(xp_data - 32'd4 == 32'h100, "R8 irq return", xp_data - 32'd4, 32'h100);
    tick();
    chk(!xp_we, "R7 single write", xp_we, 0);

    // R7 illegal opcode: 3 edges
    do_reset();
    pc_rf = 32'h200; illop_rf = 1; tick(); quiet();
    chk(xp_fwd_valid && xp_fwd_data == 32'h204, "R9 illop fwd", xp_fwd_data, 32'h204);
    tick();
    chk(!xp_we, "R7 illop early", xp_we, 0);
    tick();
    chk(xp_we && xp_data == 32'h204, "R7 illop write", xp_data, 32'h204);

    // R7 ALU fault: 2 edges
    do_reset();
    pc_alu = 32'h300; fault_alu = 1; tick(); quiet();
    chk(!xp_we, "R7 alu early", xp_we, 0);
    tick();
    chk(xp_we && xp_data == 32'h304, "R7 alu write", xp_data, 32'h304);

    // R7 memory fault: 1 edge
    do_reset();
    pc_mem = 32'h400; fault_mem = 1; tick(); quiet();
    chk(xp_we && xp_data == 32'h404, "R7 mem write", xp_data, 32'h404);

    // R10 irq link flushed by a following ALU fault
    do_reset();
    pc_if = 32'h500; irq = 1; tick(); quiet();
    pc_alu = 32'h600; fault_alu = 1; tick(); quiet();
    tick();
    chk(xp_we && xp_data == 32'h604, "R10 alu link writes", xp_data, 32'h604);
    tick();
    chk(!xp_we, "R10 flushed irq link must not write", xp_we, 0);

    // R9 two links in flight, youngest forwarded
    do_reset();
    pc_rf = 32'h900; illop_rf = 1; tick();
    pc_rf = 32'hA00; tick(); quiet();
    chk(xp_fwd_valid && xp_fwd_data == 32'hA04, "R9 youngest first", xp_fwd_data, 32'hA04);
    tick();
    chk(xp_fwd_data == 32'hA04 && xp_we && xp_data == 32'h904, "R9 wb older, fwd younger",
        {xp_fwd_data, xp_data}, {32'hA04, 32'h904});

    // R11 stall holds link in register read
    do_reset();
    pc_if = 32'hB00; irq = 1; tick(); quiet();
    stall_in = 1; #1;
    chk(stall_out, "R6 stall passes with no event", stall_out, 1);
    tick(); tick(); quiet();
    chk(!xp_fwd_valid, "R11 link held in RF", xp_fwd_valid, 0);
    tick(); tick();
    chk(!xp_we, "R11 delayed write not yet", xp_we, 0);
    tick();
    chk(xp_we && xp_data == 32'hB04, "R11 delayed write", xp_data, 32'hB04);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule